// File: doc/BRIEF.md
# Sleep/Idle Power Mode Sequencer

This block sequences a processor core through its two low-power states. A single-cycle command, qualified by `cmd_valid`, carries a one-bit argument that picks either Idle or Sleep. In Idle only the CPU clock is gated. In Sleep the CPU and peripheral clocks are both gated and the main oscillator enable is dropped. The one exception is a low-power crystal, which is allowed to keep running through Sleep.

While the core is parked, the block watches for wake events. A wake event is an interrupt line that is pending, enabled, and of higher priority than the current CPU level, or a watchdog time-out. On a wake from Idle the CPU clock returns on the next cycle. On a wake from Sleep the block first restarts the oscillator that was in use before Sleep. It then waits for a start-up period, and the rule for that period depends on the oscillator class. Every class waits a fixed power-on delay counted in cycles. Crystal sources also wait for the oscillator-stable input, and PLL sources also wait for the PLL-lock input. After that the block ungates the clocks and raises a sleep status flag.

The block reports why it woke and gives a one-cycle pulse that lets the pending interrupt be serviced. A reset request returns it to Run at once from any state.

Top module: `pwr_mode_seq`

## Requirements
- R1: After the synchronous reset `rst`, the outputs `cpu_clk_en`, `per_clk_en` and `osc_en` are 1, and `sleep_flag`, `idle_flag`, `wdt_wake` and `irq_go` are 0.
- R2: A command with `cmd_sleep`=0, accepted in Run, enters Idle. From the next cycle `cpu_clk_en`=0 while `per_clk_en`=1 and `osc_en`=1.
- R3: A command with `cmd_sleep`=1, accepted in Run, enters Sleep. From the next cycle `cpu_clk_en`=0 and `per_clk_en`=0. `osc_en` is 0 unless `osc_sel` was 5 (low-power crystal), in which case it stays 1.
- R4: The `osc_sel` encoding is: 0 external clock, 1 fast RC, 2 low-power RC, 3 external RC, 4 crystal, 5 low-power crystal, 6 PLL, 7 treated as an RC source. `lprc_en` is registered. It equals `wdt_en`, OR'd with the main oscillator running on source 2.
- R5: Interrupt line i is a wake source only when `irq_pend[i]` and `irq_en[i]` are both 1 and its priority field `irq_prio[3i+2:3i]` is strictly greater than `cpu_level`. `wdt_timeout`=1 is always a wake source. Anything else leaves Idle or Sleep unchanged.
- R6: A wake source seen in Idle returns the block to Run on the next cycle, with `cpu_clk_en`=1 and `idle_flag`=1.
- R7: For the short-delay classes (0, 1, 2, 3, 5, 7), a wake in Sleep sets `osc_en`=1 on the next cycle. `cpu_clk_en` and `per_clk_en` then return exactly `POR_CYC` cycles after the edge that sampled the wake.
- R8: For class 4 the clocks stay gated until both `POR_CYC` cycles have elapsed and `osc_stable`=1. For class 6 they stay gated until both have elapsed and `pll_lock`=1. The clocks return on the edge after the last of these conditions is met.
- R9: The clocks return from Sleep together with `sleep_flag`=1. `irq_go` pulses for one cycle when an interrupt caused the wake, from either Idle or Sleep. `wdt_wake`=1 when the watchdog time-out was present at the wake.
- R10: `rst_req`=1 in any state returns the block to Run on the next cycle, with all clock enables at 1 and all status flags cleared.
- R11: Commands arriving outside Run are ignored. Wake sources arriving in Run have no effect.
- R12: A command accepted in Run clears `sleep_flag`, `idle_flag` and `wdt_wake`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Power-save command strobe |
| cmd_sleep | input | 1 | Command argument: 1 Sleep, 0 Idle |
| osc_sel | input | 3 | Active oscillator class (see R4) |
| irq_pend | input | NIRQ | Interrupt pending lines |
| irq_en | input | NIRQ | Interrupt enable lines |
| irq_prio | input | NIRQ*PRIO_W | Per-line priority fields |
| cpu_level | input | PRIO_W | Current CPU priority level |
| rst_req | input | 1 | Any reset request |
| wdt_en | input | 1 | Watchdog enabled |
| wdt_timeout | input | 1 | Watchdog time-out |
| osc_stable | input | 1 | Oscillator start-up timer done |
| pll_lock | input | 1 | PLL locked |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Main oscillator enable |
| lprc_en | output | 1 | Low-power RC oscillator enable |
| sleep_flag | output | 1 | Woke from Sleep |
| idle_flag | output | 1 | Woke from Idle |
| wdt_wake | output | 1 | Wake caused by watchdog |
| irq_go | output | 1 | One-cycle pulse: service the wake interrupt |

## Verification
Gating after a command, the Idle return, reset requests and `lprc_en` all take effect one cycle after the sampling edge. The bench drives inputs just after a falling edge and reads the outputs at the next falling edge. For a Sleep wake, the bench counts `POR_CYC`-1 further cycles and checks that the clocks are still gated. One more cycle later it checks that they are back, along with the flags and the `irq_go` pulse. For crystal and PLL wakes, the stable or lock input is held low well past the power-on delay, and the bench checks that the clocks return exactly one cycle after the input rises.

// File: rtl/pms_pkg.sv
package pms_pkg;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_IDLE  = 2'd1,
    PM_SLEEP = 2'd2,
    PM_WAKE  = 2'd3
  } pm_state_t;

  // oscillator class codes carried on osc_sel
  localparam logic [2:0] OSC_EXT  = 3'd0;
  localparam logic [2:0] OSC_FRC  = 3'd1;
  localparam logic [2:0] OSC_LPRC = 3'd2;
  localparam logic [2:0] OSC_ERC  = 3'd3;
  localparam logic [2:0] OSC_XTAL = 3'd4;
  localparam logic [2:0] OSC_LPXT = 3'd5;
  localparam logic [2:0] OSC_PLL  = 3'd6;

  typedef enum logic [1:0] {
    WP_SHORT = 2'd0,
    WP_XTAL  = 2'd1,
    WP_PLL   = 2'd2
  } wake_path_t;

  function automatic wake_path_t path_of(logic [2:0] kind);
    case (kind)
      OSC_XTAL: path_of = WP_XTAL;
      OSC_PLL:  path_of = WP_PLL;
      default:  path_of = WP_SHORT;
    endcase
  endfunction

endpackage

// File: rtl/pms_wake_detect.sv
module pms_wake_detect #(
  parameter int NIRQ   = 4,
  parameter int PRIO_W = 3
) (
  input  logic [NIRQ-1:0]        irq_pend,
  input  logic [NIRQ-1:0]        irq_en,
  input  logic [NIRQ*PRIO_W-1:0] irq_prio,
  input  logic [PRIO_W-1:0]      cpu_level,
  input  logic                   wdt_timeout,
  output logic                   irq_hit,
  output logic                   wdt_hit
);

  logic [NIRQ-1:0] line_hit;

  for (genvar i = 0; i < NIRQ; i++) begin : g_line
    logic [PRIO_W-1:0] prio_i;
    assign prio_i      = irq_prio[i*PRIO_W +: PRIO_W];
    assign line_hit[i] = irq_pend[i] & irq_en[i] & (prio_i > cpu_level);
  end

  assign irq_hit = |line_hit;
  assign wdt_hit = wdt_timeout;

endmodule

// File: rtl/pms_start_delay.sv
module pms_start_delay
  import pms_pkg::*;
#(
  parameter int POR_CYC = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       run,
  input  wake_path_t path,
  input  logic       osc_stable,
  input  logic       pll_lock,
  output logic       done
);

  localparam int CW = (POR_CYC < 2) ? 1 : $clog2(POR_CYC);
  localparam logic [CW-1:0] LAST = CW'(POR_CYC - 1);

  logic [CW-1:0] cnt;
  logic          at_end;
  logic          path_ok;

  assign at_end = (cnt == LAST);

  always_comb begin
    case (path)
      WP_XTAL: path_ok = osc_stable;
      WP_PLL:  path_ok = pll_lock;
      default: path_ok = 1'b1;
    endcase
  end

  assign done = run & at_end & path_ok;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      cnt <= '0;
    end else if (run && !at_end) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R7: the delay counter saturates and never passes its last value
  a_r7_cnt_cap: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  // R8: the counter keeps its final value while waiting on stable or lock
  a_r8_cnt_hold: assert property (@(posedge clk) disable iff (rst)
    (run && at_end && !start) |=> (cnt == LAST));

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int NIRQ    = 4,
  parameter int PRIO_W  = 3,
  parameter int POR_CYC = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmd_valid,
  input  logic                   cmd_sleep,
  input  logic [2:0]             osc_sel,
  input  logic [NIRQ-1:0]        irq_pend,
  input  logic [NIRQ-1:0]        irq_en,
  input  logic [NIRQ*PRIO_W-1:0] irq_prio,
  input  logic [PRIO_W-1:0]      cpu_level,
  input  logic                   rst_req,
  input  logic                   wdt_en,
  input  logic                   wdt_timeout,
  input  logic                   osc_stable,
  input  logic                   pll_lock,
  output logic                   cpu_clk_en,
  output logic                   per_clk_en,
  output logic                   osc_en,
  output logic                   lprc_en,
  output logic                   sleep_flag,
  output logic                   idle_flag,
  output logic                   wdt_wake,
  output logic                   irq_go
);

  pm_state_t  st, n_st;
  logic [2:0] src_q, n_src;
  logic       cause_q, n_cause;
  logic       n_cpu, n_per, n_osc, n_lprc, n_slp, n_idl, n_wdt, n_go;
  logic       irq_hit, wdt_hit, wake_any;
  logic       dly_start, dly_done;
  wake_path_t wpath;

  pms_wake_detect #(.NIRQ(NIRQ), .PRIO_W(PRIO_W)) u_wake (
    .irq_pend    (irq_pend),
    .irq_en      (irq_en),
    .irq_prio    (irq_prio),
    .cpu_level   (cpu_level),
    .wdt_timeout (wdt_timeout),
    .irq_hit     (irq_hit),
    .wdt_hit     (wdt_hit)
  );

  assign wake_any = irq_hit | wdt_hit;
  assign wpath    = path_of(src_q);

  pms_start_delay #(.POR_CYC(POR_CYC)) u_dly (
    .clk        (clk),
    .rst        (rst),
    .start      (dly_start),
    .run        (st == PM_WAKE),
    .path       (wpath),
    .osc_stable (osc_stable),
    .pll_lock   (pll_lock),
    .done       (dly_done)
  );

  always_comb begin
    n_st      = st;
    n_cpu     = cpu_clk_en;
    n_per     = per_clk_en;
    n_osc     = osc_en;
    n_slp     = sleep_flag;
    n_idl     = idle_flag;
    n_wdt     = wdt_wake;
    n_go      = 1'b0;
    n_cause   = cause_q;
    n_src     = (st == PM_RUN) ? osc_sel : src_q;
    dly_start = 1'b0;
    if (rst_req) begin
      n_st    = PM_RUN;
      n_cpu   = 1'b1;
      n_per   = 1'b1;
      n_osc   = 1'b1;
      n_slp   = 1'b0;
      n_idl   = 1'b0;
      n_wdt   = 1'b0;
      n_cause = 1'b0;
    end else begin
      case (st)
        PM_RUN: begin
          if (cmd_valid) begin
            n_slp = 1'b0;
            n_idl = 1'b0;
            n_wdt = 1'b0;
            n_cpu = 1'b0;
            if (cmd_sleep) begin
              n_st  = PM_SLEEP;
              n_per = 1'b0;
              n_osc = (osc_sel == OSC_LPXT);
            end else begin
              n_st  = PM_IDLE;
            end
          end
        end
        PM_IDLE: begin
          if (wake_any) begin
            n_st  = PM_RUN;
            n_cpu = 1'b1;
            n_idl = 1'b1;
            n_wdt = wdt_hit;
            n_go  = irq_hit;
          end
        end
        PM_SLEEP: begin
          if (wake_any) begin
            n_st      = PM_WAKE;
            n_osc     = 1'b1;
            n_cause   = irq_hit;
            n_wdt     = wdt_hit;
            dly_start = 1'b1;
          end
        end
        default: begin
          if (dly_done) begin
            n_st  = PM_RUN;
            n_cpu = 1'b1;
            n_per = 1'b1;
            n_slp = 1'b1;
            n_go  = cause_q;
          end
        end
      endcase
    end
    n_lprc = wdt_en | (n_osc & (n_src == OSC_LPRC));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= PM_RUN;
      src_q      <= OSC_EXT;
      cause_q    <= 1'b0;
      cpu_clk_en <= 1'b1;
      per_clk_en <= 1'b1;
      osc_en     <= 1'b1;
      lprc_en    <= 1'b0;
      sleep_flag <= 1'b0;
      idle_flag  <= 1'b0;
      wdt_wake   <= 1'b0;
      irq_go     <= 1'b0;
    end else begin
      st         <= n_st;
      src_q      <= n_src;
      cause_q    <= n_cause;
      cpu_clk_en <= n_cpu;
      per_clk_en <= n_per;
      osc_en     <= n_osc;
      lprc_en    <= n_lprc;
      sleep_flag <= n_slp;
      idle_flag  <= n_idl;
      wdt_wake   <= n_wdt;
      irq_go     <= n_go;
    end
  end

  // R2: an Idle command gates only the CPU clock
  a_r2_idle_gates: assert property (@(posedge clk) disable iff (rst)
    (st == PM_RUN && cmd_valid && !cmd_sleep && !rst_req)
      |=> (!cpu_clk_en && per_clk_en && osc_en));

  // R3: a Sleep command gates CPU and peripheral clocks
  a_r3_sleep_gates: assert property (@(posedge clk) disable iff (rst)
    (st == PM_RUN && cmd_valid && cmd_sleep && !rst_req)
      |=> (!cpu_clk_en && !per_clk_en));

  // R6: a wake in Idle restores the CPU clock next cycle
  a_r6_idle_wake: assert property (@(posedge clk) disable iff (rst)
    (st == PM_IDLE && wake_any && !rst_req) |=> (cpu_clk_en && idle_flag));

  // R8: crystal class keeps clocks gated while the oscillator is not stable
  a_r8_xtal_hold: assert property (@(posedge clk) disable iff (rst)
    (st == PM_WAKE && wpath == WP_XTAL && !osc_stable && !rst_req)
      |=> !cpu_clk_en);

  // R8: PLL class keeps clocks gated until lock
  a_r8_pll_hold: assert property (@(posedge clk) disable iff (rst)
    (st == PM_WAKE && wpath == WP_PLL && !pll_lock && !rst_req)
      |=> !cpu_clk_en);

  // R9: the sleep flag rises only together with the returning clocks
  a_r9_flag_clocks: assert property (@(posedge clk) disable iff (rst)
    $rose(sleep_flag) |-> (cpu_clk_en && per_clk_en && osc_en));

  // R10: a reset request always lands in Run with clocks running
  a_r10_rst_req: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> (st == PM_RUN && cpu_clk_en && per_clk_en && osc_en
                 && !sleep_flag && !idle_flag && !wdt_wake));

  // R11: without a command, Run keeps the CPU clock running
  a_r11_run_hold: assert property (@(posedge clk) disable iff (rst)
    (st == PM_RUN && !cmd_valid) |=> cpu_clk_en);

endmodule

// File: tb/sim_pwr_mode_seq.sv
`timescale 1ns/1ps
module sim_pwr_mode_seq;

  localparam int NIRQ = 4;
  localparam int PW   = 3;
  localparam int POR  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_sleep = 1'b0;
  logic [2:0] osc_sel = 3'd0;
  logic [NIRQ-1:0] irq_pend = '0, irq_en = '0;
  logic [NIRQ*PW-1:0] irq_prio = '0;
  logic [PW-1:0] cpu_level = '0;
  logic rst_req = 1'b0, wdt_en = 1'b0, wdt_timeout = 1'b0;
  logic osc_stable = 1'b0, pll_lock = 1'b0;
  logic cpu_clk_en, per_clk_en, osc_en, lprc_en;
  logic sleep_flag, idle_flag, wdt_wake, irq_go;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pwr_mode_seq #(.NIRQ(NIRQ), .PRIO_W(PW), .POR_CYC(POR)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_sleep(cmd_sleep),
    .osc_sel(osc_sel), .irq_pend(irq_pend), .irq_en(irq_en),
    .irq_prio(irq_prio), .cpu_level(cpu_level), .rst_req(rst_req),
    .wdt_en(wdt_en), .wdt_timeout(wdt_timeout), .osc_stable(osc_stable),
    .pll_lock(pll_lock), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .osc_en(osc_en), .lprc_en(lprc_en), .sleep_flag(sleep_flag),
    .idle_flag(idle_flag), .wdt_wake(wdt_wake), .irq_go(irq_go)
  );

  function automatic bit qualifies(logic [NIRQ-1:0] p, logic [NIRQ-1:0] e,
                                   logic [NIRQ*PW-1:0] pr, logic [PW-1:0] lvl);
    bit r = 1'b0;
    for (int i = 0; i < NIRQ; i++)
      if (p[i] && e[i] && (pr[i*PW +: PW] > lvl)) r = 1'b1;
    return r;
  endfunction

  function automatic bit short_class(logic [2:0] k);
    return !(k == 3'd4 || k == 3'd6);
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_wake();
    irq_pend = '0; irq_en = '0; irq_prio = '0; cpu_level = '0;
    wdt_timeout = 1'b0;
  endtask

  task automatic command(logic sl, logic [2:0] sel);
    osc_sel = sel; cmd_sleep = sl; cmd_valid = 1'b1;
    tick();
    cmd_valid = 1'b0;
  endtask

  task automatic irq_wake_on();
    irq_pend = 4'b0100; irq_en = 4'b0100;
    irq_prio = 12'h500; cpu_level = 3'd2;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    tick(); tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk("R1 cpu_clk_en", cpu_clk_en, 1);
    chk("R1 per_clk_en", per_clk_en, 1);
    chk("R1 osc_en", osc_en, 1);
    chk("R1 flags", {sleep_flag, idle_flag, wdt_wake, irq_go}, 0);

    // R4 lprc enable in Run
    osc_sel = 3'd2; wdt_en = 1'b0; tick();
    chk("R4 lprc source run", lprc_en, 1);
    osc_sel = 3'd4; tick();
    chk("R4 lprc off", lprc_en, 0);
    wdt_en = 1'b1; tick();
    chk("R4 lprc watchdog", lprc_en, 1);
    wdt_en = 1'b0;

    // R11 wake sources in Run ignored
    irq_wake_on(); wdt_timeout = 1'b1; tick(); tick();
    chk("R11 run wake ignored", {cpu_clk_en, idle_flag, sleep_flag, irq_go}, 4'b1000);
    clear_wake();

    // R2 Idle entry
    command(1'b0, 3'd1);
    chk("R2 idle cpu", cpu_clk_en, 0);
    chk("R2 idle per/osc", {per_clk_en, osc_en}, 2'b11);
    // R11 command in Idle ignored
    command(1'b1, 3'd1);
    chk("R11 cmd in idle", {cpu_clk_en, per_clk_en}, 2'b01);
    // R5 non-qualifying: priority equal to level, and disabled line
    irq_pend = 4'b0011; irq_en = 4'b0001; irq_prio = 12'h033; cpu_level = 3'd3;
    tick();
    chk("R5 no wake", cpu_clk_en, 0);
    // R6 qualifying wake
    irq_wake_on(); tick();
    chk("R6 idle wake cpu", cpu_clk_en, 1);
    chk("R6 idle flag", idle_flag, 1);
    chk("R9 irq_go idle", irq_go, 1);
    clear_wake(); tick();
    chk("R9 irq_go pulse", irq_go, 0);

    // R12 command clears flags
    command(1'b0, 3'd1);
    chk("R12 idle flag cleared", idle_flag, 0);
    wdt_timeout = 1'b1; tick(); clear_wake();
    chk("R9 idle wdt wake", {wdt_wake, irq_go}, 2'b10);

    // R7 / R3 / R5 / R9 random short-class sleeps
    for (int it = 0; it < 24; it++) begin
      logic [2:0] sel;
      logic [NIRQ-1:0] p, e;
      logic [NIRQ*PW-1:0] pr;
      logic [PW-1:0] lv;
      bit q;
      do sel = 3'($urandom); while (!short_class(sel));
      wdt_en = 1'($urandom);
      command(1'b1, sel);
      chk("R3 sleep gates", {cpu_clk_en, per_clk_en}, 0);
      chk("R3 osc_en", osc_en, (sel == 3'd5) ? 1 : 0);
      chk("R4 lprc sleep", lprc_en,
          (wdt_en || (sel == 3'd2 && sel == 3'd5)) ? 1 : 0);
      p = NIRQ'($urandom); e = NIRQ'($urandom);
      pr = (NIRQ*PW)'($urandom); lv = PW'($urandom);
      q = qualifies(p, e, pr, lv);
      // enabled lines withheld: must not wake (R5)
      irq_pend = p; irq_en = '0; irq_prio = pr; cpu_level = lv;
      tick();
      chk("R5 disabled no wake", {cpu_clk_en, osc_en}, (sel == 3'd5) ? 1 : 0);
      irq_en = e;
      wdt_timeout = !q;
      tick();
      clear_wake();
      chk("R7 osc restart", osc_en, 1);
      repeat (POR - 1) tick();
      chk("R7 still gated", cpu_clk_en, 0);
      tick();
      chk("R7 clocks back", {cpu_clk_en, per_clk_en}, 2'b11);
      chk("R9 sleep flag", sleep_flag, 1);
      chk("R9 irq_go", irq_go, q);
      chk("R9 wdt_wake", wdt_wake, !q);
    end
    wdt_en = 1'b0;

    // R8 crystal: stable late
    osc_stable = 1'b0;
    command(1'b1, 3'd4);
    irq_wake_on(); tick(); clear_wake();
    repeat (POR + 3) tick();
    chk("R8 xtal held", cpu_clk_en, 0);
    osc_stable = 1'b1; tick();
    chk("R8 xtal release", cpu_clk_en, 1);
    // R8 crystal: stable early -> power-on delay only
    command(1'b1, 3'd4);
    wdt_timeout = 1'b1; tick(); clear_wake();
    repeat (POR - 1) tick();
    chk("R8 xtal por gated", cpu_clk_en, 0);
    tick();
    chk("R8 xtal por release", cpu_clk_en, 1);
    osc_stable = 1'b0;

    // R8 PLL
    pll_lock = 1'b0;
    command(1'b1, 3'd6);
    irq_wake_on(); tick(); clear_wake();
    repeat (POR + 5) tick();
    chk("R8 pll held", {cpu_clk_en, per_clk_en}, 0);
    pll_lock = 1'b1; tick();
    chk("R8 pll release", {cpu_clk_en, per_clk_en}, 2'b11);
    pll_lock = 1'b0;

    // R12 flags cleared by new command after a sleep wake
    command(1'b0, 3'd0);
    chk("R12 sleep flag cleared", sleep_flag, 0);

    // R10 reset request from Idle
    rst_req = 1'b1; tick(); rst_req = 1'b0;
    chk("R10 from idle", {cpu_clk_en, per_clk_en, osc_en, idle_flag}, 4'b1110);
    // R10 from Sleep
    command(1'b1, 3'd1);
    rst_req = 1'b1; tick(); rst_req = 1'b0;
    chk("R10 from sleep", {cpu_clk_en, per_clk_en, osc_en}, 3'b111);
    // R10 from wake delay
    command(1'b1, 3'd6);
    wdt_timeout = 1'b1; tick(); clear_wake();
    tick();
    rst_req = 1'b1; tick(); rst_req = 1'b0;
    chk("R10 from wake", {cpu_clk_en, per_clk_en, sleep_flag, wdt_wake}, 4'b1100);
    tick();
    chk("R10 stays run", cpu_clk_en, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule